// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block holds the byte-wide register set that software uses to set up an SMBus transfer, and the sequencer that turns one started transfer into a series of byte-level requests to a separate bit engine. The bit engine (not part of this block) drives SCL/SDA. Software first loads the command byte, the target address with its direction bit and the data bytes. It then writes the control register with the start bit set and watches the status register until the transfer has finished.

The sequencer supports quick command, send/receive byte, byte data, word data and block transfers. Each bus step is one request (bus start, byte write, byte read, bus stop). The request is held until the engine answers with a one-cycle done strobe. Bytes read from the bus go into the data registers or into a 32-entry block buffer. The host reaches that buffer through a single port whose index advances on every access.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register (status, control, command, address, data 0, data 1) reads 0 and no engine request is raised.
- R2: Offsets are status 0, control 2, command 3, address 4, data 0 at 5, data 1 at 6 and block port at 7. Command, address and both data registers read back what was written. Control reads back only bits 4:0, with bits 7:5 as zero. Offset 1 reads 0.
- R3: Writing control with bit 6 = 1 while idle starts a transfer on protocol code control bits 4:2. Status bit 0 (busy) is then 1 until the final bus stop completes. At that point busy falls and status bit 1 (done) is set in the same cycle.
- R4: Engine ops are encoded as 0 start, 1 write byte, 2 read byte and 3 stop. Every transfer opens with start and then the address byte {addr[7:1], dir}, and it closes with stop. The dir bit is address bit 0 for quick and send/receive byte (code 0, 1) and is 0 otherwise. Quick sends nothing more. Send byte writes the command. Byte data writes command then data 0. Word data writes command, data 0, data 1. A read with code 2 or 3 writes the command, issues a repeated start and then sends {addr[7:1], 1}.
- R5: Receive byte and byte-data read put the byte into data 0. Word read puts the first byte into data 0 and the second into data 1. The read request marks `eng_last` = 1 only on the final read of a transfer.
- R6: Block write (code 5, dir 0) sends the command, then the data 0 count, then that many bytes from buffer entries 0 upward. A count above 32 sends 32 bytes, and a count of 0 sends none.
- R7: Block read (code 5, dir 1) reads a count byte into data 0 after the repeated start. It then reads min(count, 32) bytes into buffer entries 0 upward. If the count is 0 it goes straight to stop.
- R8: Each block-port read or write while idle uses the current buffer index and then advances it, wrapping from 31 to 0. Any control read resets the index to 0.
- R9: An engine NACK on any write-byte op makes the next op a stop. The transfer then ends with done = 1 and status bit 2 (device error) = 1.
- R10: Protocol codes 4, 6 and 7 issue no engine op and end with done = 1 and device error = 1.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit only. If the transfer completes in the same cycle as such a write, the completion's setting of done wins.
- R12: While busy, writes to control, command, address, data and the block port have no effect, and a start request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on block port / control) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset |
| eng_req | output | 1 | Bus op request, held until done |
| eng_op | output | 2 | Op code: 0 start, 1 write, 2 read, 3 stop |
| eng_wbyte | output | 8 | Byte to send on a write op (0 otherwise) |
| eng_last | output | 1 | Final read of a transfer (master NACKs it) |
| eng_done | input | 1 | One-cycle completion of the current op |
| eng_nack | input | 1 | Slave did not acknowledge (valid with done) |
| eng_rbyte | input | 8 | Byte received on a read op (valid with done) |

## Verification
Two things can happen in the same cycle: the completion of the closing stop, which sets done, and a host write-one-to-clear of the status register. The bench's engine model makes the two meet by driving the status write itself, on the very edge where it returns done for the stop. Before that transfer the error bit is left set, so one status read afterwards shows both effects. Done must still be set because completion takes priority, and the error bit must be cleared by the write.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int DW        = 8;
  localparam int BLK_DEPTH = 32;

  localparam logic [2:0] OFS_STS = 3'd0;
  localparam logic [2:0] OFS_CTL = 3'd2;
  localparam logic [2:0] OFS_CMD = 3'd3;
  localparam logic [2:0] OFS_ADR = 3'd4;
  localparam logic [2:0] OFS_D0  = 3'd5;
  localparam logic [2:0] OFS_D1  = 3'd6;
  localparam logic [2:0] OFS_BLK = 3'd7;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_START, SQ_ADDR1, SQ_CMD, SQ_RESTART, SQ_ADDR2,
    SQ_WD0, SQ_WD1, SQ_WCNT, SQ_WBLK, SQ_RD0, SQ_RD1, SQ_RCNT,
    SQ_RBLK, SQ_STOP, SQ_BADP
  } seq_st_e;
endpackage

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  input  logic          idx_clr,
  input  logic          seq_we,
  input  logic [IW-1:0] seq_idx,
  input  logic [W-1:0]  seq_wdata,
  output logic [W-1:0]  seq_rdata
);
  localparam logic [IW-1:0] IDX_LAST = IW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] hidx_q, hidx_n;

  always_comb begin
    hidx_n = hidx_q;
    if (idx_clr)
      hidx_n = '0;
    else if (host_wr || host_rd)
      hidx_n = (hidx_q == IDX_LAST) ? '0 : hidx_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hidx_q <= '0;
    else        hidx_q <= hidx_n;
  end

  always_ff @(posedge clk) begin
    if (host_wr)     mem_q[hidx_q]  <= host_wdata;
    else if (seq_we) mem_q[seq_idx] <= seq_wdata;
  end

  assign host_rdata = mem_q[hidx_q];
  assign seq_rdata  = mem_q[seq_idx];

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_clr && (host_wr || host_rd) && hidx_q == IDX_LAST) |=> (hidx_q == '0));
  p_ctl_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> (hidx_q == '0));
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    proto,
  input  logic          rw,
  input  logic [6:0]    saddr,
  input  logic [7:0]    cmd,
  input  logic [7:0]    d0,
  input  logic [7:0]    d1,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [7:0]    eng_wbyte,
  output logic          eng_last,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rbyte,
  output logic          cap_d0_we,
  output logic          cap_d1_we,
  output logic [7:0]    cap_byte,
  output logic          buf_we,
  output logic [IW-1:0] buf_idx,
  input  logic [7:0]    buf_rdata,
  output logic          fin,
  output logic          fin_err
);
  localparam logic [IW:0] CNT_MAX = (IW+1)'(DEPTH);

  seq_st_e     st_q, st_n;
  eng_op_e     op;
  logic [IW-1:0] idx_q, idx_n;
  logic [IW:0]   cnt_q, cnt_n;
  logic          err_q, err_n;
  logic          proto_ok, first_rw, at_last;
  logic [IW:0]   clamp_d0, clamp_rx;

  function automatic logic [IW:0] clamp_cnt(input logic [7:0] v);
    if (v > 8'(DEPTH)) return CNT_MAX;
    return v[IW:0];
  endfunction

  assign proto_ok = (proto == PR_QUICK) || (proto == PR_BYTE) || (proto == PR_BDATA) ||
                    (proto == PR_WORD)  || (proto == PR_BLOCK);
  assign first_rw = (proto == PR_QUICK || proto == PR_BYTE) ? rw : 1'b0;
  assign at_last  = (({1'b0, idx_q} + (IW+1)'(1)) == cnt_q);
  assign clamp_d0 = clamp_cnt(d0);
  assign clamp_rx = clamp_cnt(eng_rbyte);

  always_comb begin
    st_n = st_q; idx_n = idx_q; cnt_n = cnt_q; err_n = err_q;
    cap_d0_we = 1'b0; cap_d1_we = 1'b0; buf_we = 1'b0;
    fin = 1'b0; fin_err = 1'b0;
    op = OP_START; eng_wbyte = '0; eng_last = 1'b0; eng_req = 1'b1;
    unique case (st_q)
      SQ_IDLE: begin
        eng_req = 1'b0;
        if (start) begin
          err_n = 1'b0; idx_n = '0;
          st_n  = proto_ok ? SQ_START : SQ_BADP;
        end
      end
      SQ_BADP: begin
        eng_req = 1'b0; fin = 1'b1; fin_err = 1'b1; st_n = SQ_IDLE;
      end
      SQ_START, SQ_RESTART: begin
        if (eng_done) st_n = (st_q == SQ_START) ? SQ_ADDR1 : SQ_ADDR2;
      end
      SQ_ADDR1: begin
        op = OP_WRITE; eng_wbyte = {saddr, first_rw};
        if (eng_done) begin
          if (proto == PR_QUICK)     st_n = SQ_STOP;
          else if (proto == PR_BYTE) st_n = rw ? SQ_RD0 : SQ_CMD;
          else                       st_n = SQ_CMD;
        end
      end
      SQ_CMD: begin
        op = OP_WRITE; eng_wbyte = cmd;
        if (eng_done) begin
          if (proto == PR_BYTE)       st_n = SQ_STOP;
          else if (rw)                st_n = SQ_RESTART;
          else if (proto == PR_BLOCK) st_n = SQ_WCNT;
          else                        st_n = SQ_WD0;
        end
      end
      SQ_ADDR2: begin
        op = OP_WRITE; eng_wbyte = {saddr, 1'b1};
        if (eng_done) st_n = (proto == PR_BLOCK) ? SQ_RCNT : SQ_RD0;
      end
      SQ_WD0: begin
        op = OP_WRITE; eng_wbyte = d0;
        if (eng_done) st_n = (proto == PR_WORD) ? SQ_WD1 : SQ_STOP;
      end
      SQ_WD1: begin
        op = OP_WRITE; eng_wbyte = d1;
        if (eng_done) st_n = SQ_STOP;
      end
      SQ_WCNT: begin
        op = OP_WRITE; eng_wbyte = d0;
        if (eng_done) begin
          cnt_n = clamp_d0; idx_n = '0;
          st_n  = (clamp_d0 == '0) ? SQ_STOP : SQ_WBLK;
        end
      end
      SQ_WBLK: begin
        op = OP_WRITE; eng_wbyte = buf_rdata;
        if (eng_done) begin
          if (at_last) st_n = SQ_STOP;
          else         idx_n = idx_q + IW'(1);
        end
      end
      SQ_RD0: begin
        op = OP_READ; eng_last = (proto != PR_WORD);
        if (eng_done) begin
          cap_d0_we = 1'b1;
          st_n = (proto == PR_WORD) ? SQ_RD1 : SQ_STOP;
        end
      end
      SQ_RD1: begin
        op = OP_READ; eng_last = 1'b1;
        if (eng_done) begin cap_d1_we = 1'b1; st_n = SQ_STOP; end
      end
      SQ_RCNT: begin
        op = OP_READ;
        if (eng_done) begin
          cap_d0_we = 1'b1; cnt_n = clamp_rx; idx_n = '0;
          st_n = (clamp_rx == '0) ? SQ_STOP : SQ_RBLK;
        end
      end
      SQ_RBLK: begin
        op = OP_READ; eng_last = at_last;
        if (eng_done) begin
          buf_we = 1'b1;
          if (at_last) st_n = SQ_STOP;
          else         idx_n = idx_q + IW'(1);
        end
      end
      SQ_STOP: begin
        op = OP_STOP;
        if (eng_done) begin fin = 1'b1; fin_err = err_q; st_n = SQ_IDLE; end
      end
      default: st_n = SQ_IDLE;
    endcase
    if (eng_done && eng_nack && eng_req && op == OP_WRITE) begin
      st_n = SQ_STOP; err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; idx_q <= '0; cnt_q <= '0; err_q <= 1'b0;
    end else begin
      st_q <= st_n; idx_q <= idx_n; cnt_q <= cnt_n; err_q <= err_n;
    end
  end

  assign eng_op   = op;
  assign cap_byte = eng_rbyte;
  assign buf_idx  = idx_q;

  p_op_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wbyte)));
  p_nack_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_nack && eng_op == OP_WRITE) |=> (eng_req && eng_op == OP_STOP));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smbh_pkg::*;
#(
  parameter int DEPTH = BLK_DEPTH,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       eng_req,
  output logic [1:0] eng_op,
  output logic [7:0] eng_wbyte,
  output logic       eng_last,
  input  logic       eng_done,
  input  logic       eng_nack,
  input  logic [7:0] eng_rbyte
);
  logic       busy_q, busy_n, done_q, done_n, err_q, err_n;
  logic [4:0] ctl_q, ctl_n;
  logic [7:0] cmd_q, cmd_n, adr_q, adr_n, d0_q, d0_n, d1_q, d1_n;
  logic       wr_ok, start, sts_wr;
  logic [2:0] proto_live;
  logic       cap_d0_we, cap_d1_we, buf_we, fin, fin_err;
  logic [7:0] cap_byte, buf_rdata, host_rdata;
  logic [IW-1:0] buf_idx;

  assign wr_ok      = reg_wr && !busy_q;
  assign start      = wr_ok && reg_addr == OFS_CTL && reg_wdata[6];
  assign sts_wr     = reg_wr && reg_addr == OFS_STS;
  assign proto_live = start ? reg_wdata[4:2] : ctl_q[4:2];

  always_comb begin
    busy_n = busy_q;
    if (start)    busy_n = 1'b1;
    else if (fin) busy_n = 1'b0;
    done_n = fin || (done_q && !(sts_wr && reg_wdata[1]));
    err_n  = (fin && fin_err) || (err_q && !(sts_wr && reg_wdata[2]));
    ctl_n  = (wr_ok && reg_addr == OFS_CTL) ? reg_wdata[4:0] : ctl_q;
    cmd_n  = (wr_ok && reg_addr == OFS_CMD) ? reg_wdata : cmd_q;
    adr_n  = (wr_ok && reg_addr == OFS_ADR) ? reg_wdata : adr_q;
    d0_n   = d0_q;
    if (cap_d0_we)                          d0_n = cap_byte;
    else if (wr_ok && reg_addr == OFS_D0)   d0_n = reg_wdata;
    d1_n   = d1_q;
    if (cap_d1_we)                          d1_n = cap_byte;
    else if (wr_ok && reg_addr == OFS_D1)   d1_n = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; ctl_q <= '0;
      cmd_q <= '0; adr_q <= '0; d0_q <= '0; d1_q <= '0;
    end else begin
      busy_q <= busy_n; done_q <= done_n; err_q <= err_n; ctl_q <= ctl_n;
      cmd_q <= cmd_n; adr_q <= adr_n; d0_q <= d0_n; d1_q <= d1_n;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_STS: reg_rdata = {5'b0, err_q, done_q, busy_q};
      OFS_CTL: reg_rdata = {3'b0, ctl_q};
      OFS_CMD: reg_rdata = cmd_q;
      OFS_ADR: reg_rdata = adr_q;
      OFS_D0:  reg_rdata = d0_q;
      OFS_D1:  reg_rdata = d1_q;
      OFS_BLK: reg_rdata = host_rdata;
      default: reg_rdata = '0;
    endcase
  end

  smbh_blkbuf #(.DEPTH(DEPTH), .W(DW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (wr_ok && reg_addr == OFS_BLK),
    .host_rd    (reg_rd && !busy_q && reg_addr == OFS_BLK),
    .host_wdata (reg_wdata),
    .host_rdata (host_rdata),
    .idx_clr    (reg_rd && reg_addr == OFS_CTL),
    .seq_we     (buf_we),
    .seq_idx    (buf_idx),
    .seq_wdata  (cap_byte),
    .seq_rdata  (buf_rdata)
  );

  smbh_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .proto     (proto_live),
    .rw        (adr_q[0]),
    .saddr     (adr_q[7:1]),
    .cmd       (cmd_q),
    .d0        (d0_q),
    .d1        (d1_q),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_wbyte (eng_wbyte),
    .eng_last  (eng_last),
    .eng_done  (eng_done),
    .eng_nack  (eng_nack),
    .eng_rbyte (eng_rbyte),
    .cap_d0_we (cap_d0_we),
    .cap_d1_we (cap_d1_we),
    .cap_byte  (cap_byte),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .buf_rdata (buf_rdata),
    .fin       (fin),
    .fin_err   (fin_err)
  );

  p_noreq_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !eng_req);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  p_fin_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done_q && !busy_q));
  p_lock_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && reg_addr == OFS_CMD) |=> $stable(cmd_q));
endmodule

// File: tb/sim_smb_host_regs.sv
module sim_smb_host_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic eng_req, eng_last, eng_done, eng_nack;
  logic [1:0] eng_op;
  logic [7:0] eng_wbyte, eng_rbyte;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
    .eng_last(eng_last), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rbyte(eng_rbyte)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [10:0] log_q [0:127];
  logic [10:0] exp_q [0:127];
  int n_ops = 0, n_rd = 0, n_exp = 0;
  int nack_at = -1, eng_lat = 0;
  bit stop_seen = 0, clr_at_stop = 0, blk_rd = 0;
  logic [7:0] blk_cnt = 0;

  function automatic logic [7:0] rd_val(input int k);
    if (blk_rd && k == 0) return blk_cnt;
    return 8'(8'h40 + k * 5);
  endfunction

  function automatic logic [7:0] bp(input int i);
    return 8'(8'hC0 ^ (i * 11));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bit-engine model
  initial begin
    eng_done = 0; eng_nack = 0; eng_rbyte = 0;
    forever begin
      @(negedge clk);
      if (eng_req && !eng_done) begin
        automatic bit did_clr = 0;
        log_q[n_ops] = {eng_op, eng_last, eng_wbyte};
        repeat (eng_lat) @(negedge clk);
        eng_done = 1;
        eng_nack = (n_ops == nack_at);
        if (eng_op == 2'd2) begin eng_rbyte = rd_val(n_rd); n_rd++; end
        if (eng_op == 2'd3) begin
          stop_seen = 1;
          if (clr_at_stop) begin
            reg_wr = 1; reg_addr = 3'd0; reg_wdata = 8'h06; did_clr = 1;
          end
        end
        n_ops++;
        @(negedge clk);
        eng_done = 0; eng_nack = 0;
        if (did_clr) begin reg_wr = 0; clr_at_stop = 0; end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic push(input logic [1:0] op, input logic last, input logic [7:0] b);
    exp_q[n_exp] = {op, last, b}; n_exp++;
  endtask

  task automatic build_exp(input logic [2:0] pr, input logic rw, input logic [6:0] a7,
                           input logic [7:0] cm, input logic [7:0] x0, input logic [7:0] x1);
    int n;
    n_exp = 0;
    if (!(pr == 0 || pr == 1 || pr == 2 || pr == 3 || pr == 5)) return;
    push(0, 0, 0);
    push(1, 0, {a7, (pr <= 1) ? rw : 1'b0});
    case (pr)
      3'd1: if (rw) push(2, 1, 0); else push(1, 0, cm);
      3'd2: begin
        push(1, 0, cm);
        if (rw) begin push(0, 0, 0); push(1, 0, {a7, 1'b1}); push(2, 1, 0); end
        else push(1, 0, x0);
      end
      3'd3: begin
        push(1, 0, cm);
        if (rw) begin push(0, 0, 0); push(1, 0, {a7, 1'b1}); push(2, 0, 0); push(2, 1, 0); end
        else begin push(1, 0, x0); push(1, 0, x1); end
      end
      3'd5: begin
        push(1, 0, cm);
        if (rw) begin
          n = (blk_cnt > 32) ? 32 : int'(blk_cnt);
          push(0, 0, 0); push(1, 0, {a7, 1'b1}); push(2, 0, 0);
          for (int i = 0; i < n; i++) push(2, (i == n - 1), 0);
        end else begin
          n = (x0 > 32) ? 32 : int'(x0);
          push(1, 0, x0);
          for (int i = 0; i < n; i++) push(1, 0, bp(i));
        end
      end
      default: ;
    endcase
    if (nack_at >= 0 && nack_at + 1 < n_exp) n_exp = nack_at + 1;
    push(3, 0, 0);
  endtask

  task automatic do_txn(input bit pre_clr, input logic [2:0] pr, input logic rw,
                        input logic [6:0] a7, input logic [7:0] cm,
                        input logic [7:0] x0, input logic [7:0] x1);
    if (pre_clr) wr_reg(3'd0, 8'h06);
    wr_reg(3'd3, cm); wr_reg(3'd4, {a7, rw}); wr_reg(3'd5, x0); wr_reg(3'd6, x1);
    n_ops = 0; n_rd = 0; stop_seen = 0;
    wr_reg(3'd2, {1'b0, 1'b1, 1'b0, pr, 2'b01});
    if (pr == 0 || pr == 1 || pr == 2 || pr == 3 || pr == 5) begin
      for (int t = 0; t < 3000 && !stop_seen; t++) @(negedge clk);
      repeat (3) @(negedge clk);
    end else repeat (4) @(negedge clk);
  endtask

  task automatic chk_ops(input string req);
    chk(n_ops == n_exp, {req, " op count"}, n_ops, n_exp);
    for (int i = 0; i < n_exp && i < n_ops; i++)
      chk(log_q[i] == exp_q[i], {req, " op"}, log_q[i], exp_q[i]);
  endtask

  initial begin
    automatic logic [7:0] d;
    int t0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(eng_req == 0, "R1 req", eng_req, 0);
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), d); chk(d == 0, "R1 reg", d, 0);
    end
    // R2 register access
    wr_reg(3'd3, 8'h5C); rd_reg(3'd3, d); chk(d == 8'h5C, "R2 cmd", d, 8'h5C);
    wr_reg(3'd4, 8'hA7); rd_reg(3'd4, d); chk(d == 8'hA7, "R2 addr", d, 8'hA7);
    wr_reg(3'd5, 8'h3E); rd_reg(3'd5, d); chk(d == 8'h3E, "R2 d0", d, 8'h3E);
    wr_reg(3'd6, 8'hE1); rd_reg(3'd6, d); chk(d == 8'hE1, "R2 d1", d, 8'hE1);
    wr_reg(3'd2, 8'hB7); rd_reg(3'd2, d); chk(d == 8'h17, "R2 ctl mask", d, 8'h17);
    rd_reg(3'd1, d); chk(d == 0, "R2 ofs1", d, 0);
    // R8 block port wrap and control-read reset
    rd_reg(3'd2, d);
    for (int i = 0; i < 33; i++) wr_reg(3'd7, 8'(i + 1));
    rd_reg(3'd2, d);
    for (int i = 0; i < 33; i++) begin
      rd_reg(3'd7, d);
      chk(d == ((i % 32 == 0) ? 8'd33 : 8'(i + 1)), "R8 blk idx", d, (i % 32 == 0) ? 33 : i + 1);
    end
    // preload block pattern
    rd_reg(3'd2, d);
    for (int i = 0; i < 32; i++) wr_reg(3'd7, bp(i));
    // R3 R4 R5 R10 sweep of protocol codes and directions
    for (int p = 0; p < 8; p++) begin
      for (int rw = 0; rw < 2; rw++) begin
        if (p == 5) continue;
        eng_lat = (p + rw) % 3; nack_at = -1; blk_rd = 0;
        build_exp(3'(p), rw[0], 7'(8'h11 * p + rw), 8'(8'h90 + p), 8'(8'h20 + p), 8'(8'hD0 + p));
        do_txn(1, 3'(p), rw[0], 7'(8'h11 * p + rw), 8'(8'h90 + p), 8'(8'h20 + p), 8'(8'hD0 + p));
        chk_ops((p == 4 || p > 5) ? "R10" : "R4");
        rd_reg(3'd0, d);
        if (p == 4 || p > 5) chk(d == 8'h06, "R10 sts", d, 8'h06);
        else                 chk(d == 8'h02, "R3 sts", d, 8'h02);
        if (rw == 1 && (p == 1 || p == 2 || p == 3)) begin
          rd_reg(3'd5, d); chk(d == rd_val(0), "R5 d0", d, rd_val(0));
          rd_reg(3'd6, d);
          chk(d == ((p == 3) ? rd_val(1) : 8'(8'hD0 + p)), "R5 d1", d, (p == 3) ? rd_val(1) : 8'hD0 + p);
        end
      end
    end
    // R6 block writes
    foreach (exp_q[k]) begin end
    for (int c = 0; c < 7; c++) begin
      automatic logic [7:0] cv = (c == 0) ? 8'd0 : (c == 1) ? 8'd1 : (c == 2) ? 8'd2 :
                                 (c == 3) ? 8'd31 : (c == 4) ? 8'd32 : (c == 5) ? 8'd33 : 8'd200;
      eng_lat = c % 2; nack_at = -1; blk_rd = 0;
      build_exp(3'd5, 1'b0, 7'h2A, 8'h77, cv, 8'h00);
      do_txn(1, 3'd5, 1'b0, 7'h2A, 8'h77, cv, 8'h00);
      chk_ops("R6");
    end
    // R7 block reads
    for (int c = 0; c < 5; c++) begin
      automatic logic [7:0] cv = (c == 0) ? 8'd0 : (c == 1) ? 8'd1 : (c == 2) ? 8'd5 :
                                 (c == 3) ? 8'd32 : 8'd40;
      automatic int n = (cv > 32) ? 32 : int'(cv);
      eng_lat = 0; nack_at = -1; blk_rd = 1; blk_cnt = cv;
      build_exp(3'd5, 1'b1, 7'h35, 8'h66, 8'h00, 8'h00);
      do_txn(1, 3'd5, 1'b1, 7'h35, 8'h66, 8'h00, 8'h00);
      chk_ops("R7");
      rd_reg(3'd5, d); chk(d == cv, "R7 count", d, cv);
      rd_reg(3'd2, d);
      for (int i = 0; i < n; i++) begin
        rd_reg(3'd7, d); chk(d == rd_val(i + 1), "R7 buf", d, rd_val(i + 1));
      end
    end
    blk_rd = 0;
    rd_reg(3'd2, d);
    for (int i = 0; i < 32; i++) wr_reg(3'd7, bp(i));
    // R9 NACK on each write-byte op of a word write, and mid-block
    for (int k = 1; k < 5; k++) begin
      eng_lat = 1; nack_at = k;
      build_exp(3'd3, 1'b0, 7'h4B, 8'h12, 8'h34, 8'h56);
      do_txn(1, 3'd3, 1'b0, 7'h4B, 8'h12, 8'h34, 8'h56);
      chk_ops("R9");
      rd_reg(3'd0, d); chk(d == 8'h06, "R9 sts", d, 8'h06);
    end
    nack_at = 5;
    build_exp(3'd5, 1'b0, 7'h4B, 8'h12, 8'd3, 8'h00);
    do_txn(1, 3'd5, 1'b0, 7'h4B, 8'h12, 8'd3, 8'h00);
    chk_ops("R9 blk");
    rd_reg(3'd0, d); chk(d == 8'h06, "R9 blk sts", d, 8'h06);
    nack_at = -1;
    // R11 per-bit clear
    wr_reg(3'd0, 8'h02); rd_reg(3'd0, d); chk(d == 8'h04, "R11 w1c done", d, 8'h04);
    wr_reg(3'd0, 8'h02); wr_reg(3'd0, 8'h04); rd_reg(3'd0, d); chk(d == 8'h00, "R11 w1c err", d, 0);
    // R11 clear in the completion cycle: leave err set, then clear on stop
    do_txn(1, 3'd7, 1'b0, 7'h01, 8'h00, 8'h00, 8'h00);
    clr_at_stop = 1; eng_lat = 2;
    build_exp(3'd0, 1'b1, 7'h19, 8'h00, 8'h00, 8'h00);
    do_txn(0, 3'd0, 1'b1, 7'h19, 8'h00, 8'h00, 8'h00);
    chk_ops("R11");
    rd_reg(3'd0, d); chk(d == 8'h02, "R11 set wins", d, 8'h02);
    // R12 writes and start while busy
    eng_lat = 20;
    build_exp(3'd3, 1'b0, 7'h62, 8'hAB, 8'hCD, 8'hEF);
    wr_reg(3'd0, 8'h06);
    wr_reg(3'd3, 8'hAB); wr_reg(3'd4, {7'h62, 1'b0}); wr_reg(3'd5, 8'hCD); wr_reg(3'd6, 8'hEF);
    n_ops = 0; n_rd = 0; stop_seen = 0;
    wr_reg(3'd2, 8'h4C);
    repeat (5) @(negedge clk);
    wr_reg(3'd3, 8'h99); wr_reg(3'd5, 8'h11); wr_reg(3'd2, 8'h40);
    rd_reg(3'd2, d);
    for (int t = 0; t < 3000 && !stop_seen; t++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk_ops("R12");
    rd_reg(3'd3, d); chk(d == 8'hAB, "R12 cmd", d, 8'hAB);
    rd_reg(3'd5, d); chk(d == 8'hCD, "R12 d0", d, 8'hCD);
    rd_reg(3'd2, d); chk(d == 8'h0C, "R12 ctl", d, 8'h0C);
    chk(eng_req == 0, "R12 no restart", eng_req, 0);
    t0 = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule